// File: doc/BRIEF.md
# Three-Bank Serial EEPROM Target Port

This block is the two-wire serial target that sits in front of a byte memory split into three banks of 256 bytes. A system clock samples the SCL and SDA lines. Both lines pass through a two-flop synchronizer and a short stability filter. The block then finds START and STOP conditions and collects bytes on the rising edges of SCL. It answers on the data line through an active-low open-drain enable, which it changes only after a falling edge of SCL.

A command opens with a device byte. Its top five bits are a fixed identifier, the next two bits pick the bank, and the last bit gives the direction. Write data is held in an eight-byte page buffer, with a mask that marks which bytes have arrived. The buffer moves into the array only when the master closes the command with STOP. A programming timer then runs for a set number of clock cycles. While it runs, the port answers no command. The write-enable input must stay high for the port to respond and for programming to finish.

Top module: `eep_i2c_port`

## Requirements
- R1: The device byte is accepted and acknowledged (data line pulled low in the ninth bit) only when bits 7..3 equal 10100, the write-enable input is high and no programming cycle is running. Any other identifier gets no acknowledge.
- R2: Device byte bits 2..1 (the bank code) select the bank: 01, 10 and 11 address three separate banks, and code 00 gets no acknowledge. Bit 0 is the direction, with 1 meaning read and 0 meaning write.
- R3: Data received in a write command reaches the array only if a STOP ends the command. A repeated START in place of the STOP leaves memory unchanged and starts no programming cycle.
- R4: During a write, only the low three bits of the word address advance after each data byte. More than eight bytes wrap around and overwrite bytes inside the same eight-byte page.
- R5: After a committing STOP, the port gives no acknowledge to any device byte for PROG_CYCLES plus nine clock cycles. After that, a device byte is acknowledged again, so the master can poll for completion.
- R6: A random read writes a word address with the direction bit at 0, then sends a repeated START and a device byte with the direction bit at 1. The port returns the byte stored at that address.
- R7: In a read, every byte sent advances the 8-bit address, with a wrap from 255 to 0. A master acknowledge causes the next byte to be sent. A master not-acknowledge ends the transfer and releases the line.
- R8: A read that sends no word address (current read) returns the byte after the last byte read. If a write was committed since that read, it returns the byte at the last address written.
- R9: The data-line enable changes only while SCL is low. START or STOP aborts any command and releases the line.
- R10: If write-enable goes low while a programming cycle runs, programming stops at once, the cycle ends, and bytes not yet stored keep their old values.
- R11: With write-enable low, the port acknowledges no device byte.
- R12: After reset every array byte reads FFh and the data line is released.
- R13: Only the page-buffer bytes actually received are stored. The other bytes of the page keep their old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wr_en | input | 1 | Port enable and programming enable, active high |
| sda_oe_n | output | 1 | Open-drain data drive: 0 pulls the line low |

## Verification
The checks assume a well-behaved master. It changes SDA only while SCL is low, except for the SDA edge that forms a START or STOP, and it never issues START or STOP while the target is pulling the line low. The bench master keeps to this. It moves SDA one quarter bit after SCL falls and samples in the middle of the high phase. Each quarter bit is longer than the synchronizer and filter delay, so the filtered lines keep the same order of edges as the bus. Write-enable is changed only between bytes, or while a programming cycle is running.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Serial protocol engine state
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RX,     // shifting in a byte
    ST_SACK,   // target acknowledge bit
    ST_TX,     // shifting out a byte
    ST_MACK    // master acknowledge bit
  } st_e;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    K_DEV,
    K_WORD,
    K_DATA
  } kind_e;

  // Fixed upper bits of the device byte: identifier 1010 followed by 0
  localparam logic [4:0] DEV_ID = 5'b10100;

endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q, out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (s2_q != out_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) out_d = s2_q;
      else                            cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/eep_bank_array.sv
module eep_bank_array #(
  parameter int NBANK = 3,
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int BW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [BW-1:0] wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int WORDS = NBANK * DEPTH;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (we) begin
      mem[{wbank, waddr}] <= wdata;
    end
  end

  assign rdata = ({1'b0, rbank} < (BW+1)'(NBANK)) ? mem[{rbank, raddr}] : '1;

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ({1'b0, wbank} < (BW+1)'(NBANK))); // R2
endmodule

// File: rtl/eep_prog_ctrl.sv
module eep_prog_ctrl #(
  parameter int PROG_CYCLES = 600,
  parameter int PAGE_BYTES  = 8,
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int BW          = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     go,
  input  logic [BW-1:0]            go_bank,
  input  logic [AW-$clog2(PAGE_BYTES)-1:0] go_page,
  input  logic [PAGE_BYTES-1:0]    go_mask,
  input  logic [PAGE_BYTES*DW-1:0] go_data,
  output logic                     busy,
  output logic                     we,
  output logic [BW-1:0]            we_bank,
  output logic [AW-1:0]            we_addr,
  output logic [DW-1:0]            we_data
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic                     busy_q, busy_d, commit_q, commit_d;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [PW-1:0]            idx_q, idx_d;
  logic [BW-1:0]            bank_q, bank_d;
  logic [AW-PW-1:0]         page_q, page_d;
  logic [PAGE_BYTES-1:0]    mask_q, mask_d;
  logic [PAGE_BYTES*DW-1:0] data_q, data_d;

  always_comb begin
    busy_d   = busy_q;
    commit_d = commit_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    bank_d   = bank_q;
    page_d   = page_q;
    mask_d   = mask_q;
    data_d   = data_q;
    if (!busy_q) begin
      if (go) begin
        busy_d   = 1'b1;
        commit_d = 1'b0;
        cnt_d    = CW'(PROG_CYCLES - 1);
        idx_d    = '0;
        bank_d   = go_bank;
        page_d   = go_page;
        mask_d   = go_mask;
        data_d   = go_data;
      end
    end else if (!wr_en) begin
      busy_d   = 1'b0;
      commit_d = 1'b0;
      mask_d   = '0;
    end else if (!commit_q) begin
      if (cnt_q == '0) commit_d = 1'b1;
      else             cnt_d    = cnt_q - CW'(1);
    end else begin
      if (idx_q == PW'(PAGE_BYTES - 1)) begin
        busy_d   = 1'b0;
        commit_d = 1'b0;
      end else begin
        idx_d = idx_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      commit_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      bank_q   <= '0;
      page_q   <= '0;
      mask_q   <= '0;
      data_q   <= '0;
    end else begin
      busy_q   <= busy_d;
      commit_q <= commit_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      bank_q   <= bank_d;
      page_q   <= page_d;
      mask_q   <= mask_d;
      data_q   <= data_d;
    end
  end

  assign busy    = busy_q;
  assign we      = busy_q && commit_q && wr_en && mask_q[idx_q];
  assign we_bank = bank_q;
  assign we_addr = {page_q, idx_q};
  assign we_data = data_q[idx_q*DW +: DW];

  AST_ABORT_ON_WREN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wr_en) |=> !busy_q); // R10
endmodule

// File: rtl/eep_i2c_port.sv
module eep_i2c_port #(
  parameter int PROG_CYCLES = 600,
  parameter int FILT_LEN    = 3,
  parameter int NBANK       = 3,
  parameter int PAGE_BYTES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_en,
  output logic sda_oe_n
);
  import eep_pkg::*;

  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int BW  = 2;
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int BCW = $clog2(DW + 1);
  localparam int PBW = PAGE_BYTES * DW;

  // ---------------- line conditioning ----------------
  logic [1:0] line_raw, line_flt;
  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    eep_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw[g]),
      .dout (line_flt[g])
    );
  end

  logic scl_f, sda_f, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_f     = line_flt[1];
  assign sda_f     = line_flt[0];
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

  // ---------------- protocol state ----------------
  st_e              st_q, st_d;
  kind_e            kind_q, kind_d;
  logic [BCW-1:0]   bcnt_q, bcnt_d;
  logic [DW-1:0]    sh_q, sh_d, tx_q, tx_d;
  logic             rw_q, rw_d, mack_q, mack_d, oe_n_q, oe_n_d;
  logic [BW-1:0]    bank_q, bank_d;
  logic [AW-1:0]    ptr_q, ptr_d, waddr_q, waddr_d, lastwr_q, lastwr_d;
  logic [PBW-1:0]   pbuf_q, pbuf_d;
  logic [PAGE_BYTES-1:0] pmask_q, pmask_d;
  logic [AW-PW-1:0] page_q, page_d;

  logic             prog_go, prog_busy, mem_we;
  logic [BW-1:0]    mem_wbank;
  logic [AW-1:0]    mem_waddr;
  logic [DW-1:0]    mem_wdata, rd_data;
  logic [1:0]       sel;
  logic             dev_ok;

  assign sel    = sh_q[2:1];
  assign dev_ok = (sh_q[7:3] == DEV_ID) && (sel != 2'b00) &&
                  ({1'b0, sel} <= 3'(NBANK)) && wr_en && !prog_busy;

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    bcnt_d   = bcnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    bank_d   = bank_q;
    ptr_d    = ptr_q;
    waddr_d  = waddr_q;
    lastwr_d = lastwr_q;
    pbuf_d   = pbuf_q;
    pmask_d  = pmask_q;
    page_d   = page_q;
    tx_d     = tx_q;
    mack_d   = mack_q;
    oe_n_d   = oe_n_q;
    prog_go  = 1'b0;

    if (start_det) begin
      st_d    = ST_RX;
      kind_d  = K_DEV;
      bcnt_d  = '0;
      pmask_d = '0;
      oe_n_d  = 1'b1;
    end else if (stop_det) begin
      if ((st_q == ST_RX || st_q == ST_SACK) && kind_q == K_DATA && pmask_q != '0) begin
        prog_go = 1'b1;
        ptr_d   = lastwr_q;
      end
      st_d    = ST_IDLE;
      pmask_d = '0;
      oe_n_d  = 1'b1;
    end else if (scl_rise) begin
      case (st_q)
        ST_RX: if (bcnt_q < BCW'(DW)) begin
          sh_d   = {sh_q[DW-2:0], sda_f};
          bcnt_d = bcnt_q + BCW'(1);
        end
        ST_TX:   bcnt_d = bcnt_q + BCW'(1);
        ST_MACK: mack_d = ~sda_f;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st_q)
        ST_RX: if (bcnt_q == BCW'(DW)) begin
          bcnt_d = '0;
          case (kind_q)
            K_DEV: begin
              if (dev_ok) begin
                rw_d   = sh_q[0];
                bank_d = BW'(sel - 2'd1);
                st_d   = ST_SACK;
                oe_n_d = 1'b0;
              end else begin
                st_d = ST_IDLE;
              end
            end
            K_WORD: begin
              ptr_d   = sh_q;
              waddr_d = sh_q;
              st_d    = ST_SACK;
              oe_n_d  = 1'b0;
            end
            default: begin
              if (wr_en) begin
                pbuf_d[waddr_q[PW-1:0]*DW +: DW] = sh_q;
                pmask_d[waddr_q[PW-1:0]]         = 1'b1;
                page_d   = waddr_q[AW-1:PW];
                lastwr_d = waddr_q;
                waddr_d  = {waddr_q[AW-1:PW], waddr_q[PW-1:0] + PW'(1)};
                st_d     = ST_SACK;
                oe_n_d   = 1'b0;
              end else begin
                st_d = ST_IDLE;
              end
            end
          endcase
        end
        ST_SACK: begin
          oe_n_d = 1'b1;
          if (kind_q == K_DEV && rw_q) begin
            tx_d   = rd_data;
            oe_n_d = rd_data[DW-1];
            st_d   = ST_TX;
          end else begin
            if (kind_q == K_DEV)       kind_d = K_WORD;
            else if (kind_q == K_WORD) kind_d = K_DATA;
            st_d = ST_RX;
          end
        end
        ST_TX: begin
          if (bcnt_q == BCW'(DW)) begin
            oe_n_d = 1'b1;
            ptr_d  = ptr_q + AW'(1);
            bcnt_d = '0;
            st_d   = ST_MACK;
          end else begin
            tx_d   = tx_q << 1;
            oe_n_d = tx_q[DW-2];
          end
        end
        ST_MACK: begin
          if (mack_q) begin
            tx_d   = rd_data;
            oe_n_d = rd_data[DW-1];
            st_d   = ST_TX;
          end else begin
            st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= K_DEV;
      bcnt_q   <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      bank_q   <= '0;
      ptr_q    <= '0;
      waddr_q  <= '0;
      lastwr_q <= '0;
      pbuf_q   <= '0;
      pmask_q  <= '0;
      page_q   <= '0;
      tx_q     <= '0;
      mack_q   <= 1'b0;
      oe_n_q   <= 1'b1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      st_q     <= st_d;
      kind_q   <= kind_d;
      bcnt_q   <= bcnt_d;
      sh_q     <= sh_d;
      rw_q     <= rw_d;
      bank_q   <= bank_d;
      ptr_q    <= ptr_d;
      waddr_q  <= waddr_d;
      lastwr_q <= lastwr_d;
      pbuf_q   <= pbuf_d;
      pmask_q  <= pmask_d;
      page_q   <= page_d;
      tx_q     <= tx_d;
      mack_q   <= mack_d;
      oe_n_q   <= oe_n_d;
      scl_p    <= scl_f;
      sda_p    <= sda_f;
    end
  end

  assign sda_oe_n = oe_n_q;

  // ---------------- programming timer and array ----------------
  eep_prog_ctrl #(
    .PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES),
    .AW(AW), .DW(DW), .BW(BW)
  ) u_prog (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .go     (prog_go),
    .go_bank(bank_q),
    .go_page(page_q),
    .go_mask(pmask_q),
    .go_data(pbuf_q),
    .busy   (prog_busy),
    .we     (mem_we),
    .we_bank(mem_wbank),
    .we_addr(mem_waddr),
    .we_data(mem_wdata)
  );

  eep_bank_array #(.NBANK(NBANK), .AW(AW), .DW(DW), .BW(BW)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .wbank(mem_wbank),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .rbank(bank_q),
    .raddr(ptr_q),
    .rdata(rd_data)
  );

  // ---------------- assertions ----------------
  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SACK && kind_q == K_DEV) |-> !prog_busy); // R5

  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && scl_p) |=> $stable(sda_oe_n)); // R9

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> sda_oe_n); // R9

  AST_DRIVE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe_n |-> (st_q == ST_SACK || st_q == ST_TX)); // R9
endmodule

// File: tb/test_eep_i2c_port.sv
module test_eep_i2c_port;

  localparam int Q  = 8;       // system clocks per quarter bit
  localparam int NV = 7;

  // {bank code, word address, data}
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 8'hFE, 8'h5A},
    {2'd1, 8'hFF, 8'hA5},
    {2'd1, 8'h00, 8'h3C},
    {2'd2, 8'h00, 8'hC3},
    {2'd3, 8'h00, 8'h96},
    {2'd3, 8'h80, 8'h01},
    {2'd2, 8'h7F, 8'h00}
  };

  logic clk, rst_n, scl_m, sda_m, wr_en, sda_oe_n, done;
  wire  sda_bus = sda_m & sda_oe_n;
  int   checks, errors;

  eep_i2c_port #(.PROG_CYCLES(600)) i_eep_i2c_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .wr_en   (wr_en),
    .sda_oe_n(sda_oe_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; qwait;
    scl_m = 1'b1; qwait;
    sda_m = 1'b0; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; qwait;
    scl_m = 1'b1; qwait;
    sda_m = 1'b1; qwait;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait;
    scl_m = 1'b1; qwait; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait;
    scl_m = 1'b1; qwait;
    b = sda_bus; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~give_ack);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] p, input logic rd);
    return {5'b10100, p, rd};
  endfunction

  task automatic byte_write(input logic [1:0] p, input logic [7:0] a,
                            input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start;
    send_byte(dev(p, 1'b0), a0);
    send_byte(a, a1);
    send_byte(d, a2);
    i2c_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic poll(input logic [1:0] p, output logic ack);
    i2c_start;
    send_byte(dev(p, 1'b0), ack);
    i2c_stop;
  endtask

  task automatic wait_ready(input logic [1:0] p, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 20 && !ok; i++) poll(p, ok);
  endtask

  task automatic rand_read(input logic [1:0] p, input logic [7:0] a,
                           output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start;
    send_byte(dev(p, 1'b0), a0);
    send_byte(a, a1);
    i2c_start;
    send_byte(dev(p, 1'b1), a2);
    recv_byte(1'b0, d);
    i2c_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic cur_read(input logic [1:0] p, output logic [7:0] d, output logic ok);
    i2c_start;
    send_byte(dev(p, 1'b1), ok);
    recv_byte(1'b0, d);
    i2c_stop;
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, ack;
    logic [7:0] d;
    logic [7:0] pg [8];
    checks = 0; errors = 0;
    scl_m = 1'b1; sda_m = 1'b1; wr_en = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R12 reset state
    chk("R12 line released after reset", {7'd0, sda_oe_n}, 8'h01);
    rand_read(2'd1, 8'h10, d, ok);
    chk("R12 read ack", {7'd0, ok}, 8'h01);
    chk("R12 erased byte", d, 8'hFF);

    // Vector table: write, busy refusal, poll, read back
    for (int v = 0; v < NV; v++) begin
      byte_write(VEC[v][17:16], VEC[v][15:8], VEC[v][7:0], ok);
      chk("R1 write command acknowledged", {7'd0, ok}, 8'h01);
      poll(VEC[v][17:16], ack);
      chk("R5 no ack while programming", {7'd0, ack}, 8'h00);
      wait_ready(VEC[v][17:16], ok);
      chk("R5 ack after programming", {7'd0, ok}, 8'h01);
      rand_read(VEC[v][17:16], VEC[v][15:8], d, ok);
      chk("R6 random read ack", {7'd0, ok}, 8'h01);
      chk("R6 random read data", d, VEC[v][7:0]);
    end

    // R2 bank isolation at address 0
    rand_read(2'd1, 8'h00, d, ok); chk("R2 bank code 01", d, 8'h3C);
    rand_read(2'd2, 8'h00, d, ok); chk("R2 bank code 10", d, 8'hC3);
    rand_read(2'd3, 8'h00, d, ok); chk("R2 bank code 11", d, 8'h96);

    // R2 code 00 and R1 wrong identifier are refused
    i2c_start; send_byte(dev(2'd0, 1'b0), ack); i2c_stop;
    chk("R2 bank code 00 nack", {7'd0, ack}, 8'h00);
    i2c_start; send_byte(8'hB2, ack); i2c_stop;
    chk("R1 wrong identifier nack", {7'd0, ack}, 8'h00);

    // R7 sequential read with wrap 255 -> 0
    i2c_start;
    send_byte(dev(2'd1, 1'b0), ack);
    send_byte(8'hFE, ack);
    i2c_start;
    send_byte(dev(2'd1, 1'b1), ack);
    recv_byte(1'b1, d); chk("R7 seq byte FE", d, 8'h5A);
    recv_byte(1'b1, d); chk("R7 seq byte FF", d, 8'hA5);
    recv_byte(1'b0, d); chk("R7 seq wrap to 00", d, 8'h3C);
    i2c_stop;
    chk("R9 line released after STOP", {7'd0, sda_oe_n}, 8'h01);
    // R8 current read after read: address 01
    cur_read(2'd1, d, ok);
    chk("R8 current read after read ack", {7'd0, ok}, 8'h01);
    chk("R8 current read after read", d, 8'hFF);

    // R4 page write of 10 bytes from 0x15 in bank code 10
    for (int i = 0; i < 8; i++) pg[i] = 8'hFF;
    i2c_start;
    send_byte(dev(2'd2, 1'b0), ack);
    send_byte(8'h15, ack);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'hD0 + 8'(i), ack);
      pg[(5 + i) % 8] = 8'hD0 + 8'(i);
    end
    i2c_stop;
    wait_ready(2'd2, ok);
    chk("R5 ready after page write", {7'd0, ok}, 8'h01);
    cur_read(2'd2, d, ok);
    chk("R8 current read after write", d, 8'hD9);
    i2c_start;
    send_byte(dev(2'd2, 1'b0), ack);
    send_byte(8'h10, ack);
    i2c_start;
    send_byte(dev(2'd2, 1'b1), ack);
    for (int i = 0; i < 8; i++) begin
      recv_byte(1'b1, d);
      chk("R4 page wrap content", d, pg[i]);
    end
    recv_byte(1'b0, d);
    chk("R4 next page untouched", d, 8'hFF);
    i2c_stop;

    // R13 partial page: only received bytes stored
    i2c_start;
    send_byte(dev(2'd3, 1'b0), ack);
    send_byte(8'h40, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    i2c_stop;
    wait_ready(2'd3, ok);
    rand_read(2'd3, 8'h41, d, ok); chk("R13 received byte stored", d, 8'h22);
    rand_read(2'd3, 8'h42, d, ok); chk("R13 unreceived byte kept", d, 8'hFF);
    rand_read(2'd3, 8'h47, d, ok); chk("R13 page end kept", d, 8'hFF);

    // R3 repeated START instead of STOP discards write
    i2c_start;
    send_byte(dev(2'd3, 1'b0), ack);
    send_byte(8'h30, ack);
    send_byte(8'h99, ack);
    i2c_start;
    i2c_stop;
    poll(2'd3, ack);
    chk("R3 no programming without STOP", {7'd0, ack}, 8'h01);
    rand_read(2'd3, 8'h30, d, ok);
    chk("R3 memory unchanged", d, 8'hFF);

    // R10 write-enable drop aborts programming
    byte_write(2'd1, 8'h33, 8'h77, ok);
    repeat (50) @(negedge clk);
    wr_en = 1'b0;
    repeat (5) @(negedge clk);
    wr_en = 1'b1;
    poll(2'd1, ack);
    chk("R10 busy ended by abort", {7'd0, ack}, 8'h01);
    rand_read(2'd1, 8'h33, d, ok);
    chk("R10 aborted byte not stored", d, 8'hFF);

    // R11 write-enable low refuses commands
    wr_en = 1'b0;
    i2c_start; send_byte(dev(2'd1, 1'b1), ack); i2c_stop;
    chk("R11 nack with write-enable low", {7'd0, ack}, 8'h00);
    wr_en = 1'b1;
    poll(2'd1, ack);
    chk("R11 ack restored", {7'd0, ack}, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule